// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit with Selectable Overflow Reporting

This block is a purely combinational integer arithmetic/logic unit for a 32-bit datapath. It accepts two 32-bit operands and a 4-bit operation code. It returns a 32-bit result, a flag that is high when the result is all zeros, and a signed-overflow flag. The operation set covers four bitwise operations, addition, subtraction, and signed and unsigned less-than comparison.

A second operand can come from a 16-bit immediate instead of the register operand. The immediate is widened with sign replication for the arithmetic and compare operations, and with zero fill for the bitwise operations. A separate trap-enable input chooses between the trapping and non-trapping forms of add and subtract. Overflow is reported only when that input is high and the operation is add or subtract.

Internally, a decoder turns the operation code into a small bundle of strobes. A datapath holds the immediate widener, a single adder used for every arithmetic and compare operation, the bitwise unit and the result selector.

Top module: `alu_core`

## Requirements
- R1: The bitwise codes produce the bitwise result of the two operands: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, 3 gives NOT(A OR B).
- R2: Code 4 gives A + B modulo 2^32. Code 5 gives A - B modulo 2^32, formed as A + NOT B + 1.
- R3: With trap enable high and code 4, the overflow flag is set when both operands are non-negative and the result is negative. It is also set when both operands are negative and the result is non-negative.
- R4: With trap enable high and code 5, the overflow flag is set when A is non-negative, B is negative and the result is negative. It is also set when A is negative, B is non-negative and the result is non-negative.
- R5: Adding operands of opposite sign never sets the overflow flag. Subtracting operands of equal sign never sets it either.
- R6: With trap enable low, add and subtract never set the overflow flag, and their result is the same as with trap enable high.
- R7: The bitwise and compare codes (0, 1, 2, 3, 6, 7) never set the overflow flag, whatever the trap enable.
- R8: Code 6 gives 1 when A is less than B as signed numbers and 0 otherwise. This holds even when A - B overflows.
- R9: Code 7 gives 1 when A is less than B as unsigned numbers and 0 otherwise.
- R10: With the immediate select high, the second operand is the 16-bit immediate. For codes 4 to 7 the immediate is widened by copying its bit 15 into bits 31:16. For codes 0 to 3 bits 31:16 are zero.
- R11: The zero flag is high exactly when all 32 result bits are 0, for every code.
- R12: Codes 8 to 15 give a result of 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (register form) |
| immVal | input | 16 | Immediate used in place of opB |
| useImm | input | 1 | Selects the widened immediate as second operand |
| opSel | input | 4 | Operation code |
| trapEn | input | 1 | Enables signed overflow reporting for add and subtract |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | High when result is all zeros |
| ovfFlag | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The bench targets the four sign combinations of add and subtract at the extremes 0x7FFFFFFF and 0x80000000. A design that tests the register B instead of the effective B would flag a subtract of equal-sign operands, or miss a real subtract overflow. Signed less-than is driven with operand pairs whose difference overflows, where a design using the raw difference sign gives the inverted answer. Unsigned less-than is driven with high-bit operands, where a signed compare disagrees. Immediates with bit 15 set are applied to both arithmetic and bitwise codes, which exposes swapped sign and zero widening. Undefined codes and trap-disabled overflow cases catch designs that fall through to the adder output or report overflow unconditionally.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLTU = 4'd7
  } aluOp_e;

  typedef enum logic [2:0] {
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOR,
    SEL_SUM,
    SEL_LTS,
    SEL_LTU,
    SEL_ZERO
  } resSel_e;

  // strobes from decoder to datapath
  typedef struct packed {
    logic    invB;     // invert second operand before the adder
    logic    carryIn;  // adder carry in
    logic    signExt;  // immediate widening: 1 = replicate top bit
    logic    ovfEn;    // report signed overflow
    resSel_e resSel;   // result source
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opSel,
  input  logic            trapEn,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{invB: 1'b0, carryIn: 1'b0, signExt: 1'b0, ovfEn: 1'b0, resSel: SEL_ZERO};
    case (opSel)
      OP_AND:  ctrl.resSel = SEL_AND;
      OP_OR:   ctrl.resSel = SEL_OR;
      OP_XOR:  ctrl.resSel = SEL_XOR;
      OP_NOR:  ctrl.resSel = SEL_NOR;
      OP_ADD: begin
        ctrl.signExt = 1'b1;
        ctrl.ovfEn   = trapEn;
        ctrl.resSel  = SEL_SUM;
      end
      OP_SUB: begin
        ctrl.invB    = 1'b1;
        ctrl.carryIn = 1'b1;
        ctrl.signExt = 1'b1;
        ctrl.ovfEn   = trapEn;
        ctrl.resSel  = SEL_SUM;
      end
      OP_SLT: begin
        ctrl.invB    = 1'b1;
        ctrl.carryIn = 1'b1;
        ctrl.signExt = 1'b1;
        ctrl.resSel  = SEL_LTS;
      end
      OP_SLTU: begin
        ctrl.invB    = 1'b1;
        ctrl.carryIn = 1'b1;
        ctrl.signExt = 1'b1;
        ctrl.resSel  = SEL_LTU;
      end
      default: ctrl.resSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              useImm,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] immWide;
  logic [DATA_W-1:0] bSel;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              rawOvf;
  logic              lessSigned;
  logic              lessUnsigned;

  generate
    if (EXT_W > 0) begin : g_widen
      always_comb
        immWide = ctrl.signExt ? {{EXT_W{immVal[IMM_W-1]}}, immVal}
                               : {{EXT_W{1'b0}}, immVal};
    end else begin : g_nowiden
      always_comb immWide = immVal[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    bSel = useImm ? immWide : opB;
    bEff = ctrl.invB ? ~bSel : bSel;
    {carryOut, sum} = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, ctrl.carryIn};
    // operands entering the adder agree in sign but the sum does not
    rawOvf       = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
    lessSigned   = sum[MSB] ^ rawOvf;
    lessUnsigned = ~carryOut;
  end

  always_comb begin
    case (ctrl.resSel)
      SEL_AND:  result = opA & bSel;
      SEL_OR:   result = opA | bSel;
      SEL_XOR:  result = opA ^ bSel;
      SEL_NOR:  result = ~(opA | bSel);
      SEL_SUM:  result = sum;
      SEL_LTS:  result = {{(DATA_W-1){1'b0}}, lessSigned};
      SEL_LTU:  result = {{(DATA_W-1){1'b0}}, lessUnsigned};
      default:  result = '0;
    endcase
    zeroFlag = ~|result;
    ovfFlag  = ctrl.ovfEn & rawOvf;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              useImm,
  input  logic [OP_W-1:0]   opSel,
  input  logic              trapEn,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  aluCtrl_t ctrl;

  alu_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opSel  (opSel),
    .trapEn (trapEn),
    .ctrl   (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .immVal   (immVal),
    .useImm   (useImm),
    .ctrl     (ctrl),
    .result   (result),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 4
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IMM_W-1:0]  immVal,
  input logic              useImm,
  input logic [OP_W-1:0]   opSel,
  input logic              trapEn,
  input logic [DATA_W-1:0] result,
  input logic              zeroFlag,
  input logic              ovfFlag
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bUsed;
  logic              isAdd;
  logic              isSub;
  logic              isCmp;

  always_comb begin
    bUsed = useImm ? {{(DATA_W-IMM_W){immVal[IMM_W-1] & opSel[2]}}, immVal} : opB;
    isAdd = (opSel == 4)  ;
    isSub = (opSel == 5);
    isCmp = (opSel == 6) || (opSel == 7);
  end

  always_comb begin
    p_zero_flag_r11: assert (zeroFlag == (result == '0))
      else $error("zero flag disagrees with result");
    p_no_overflow_r6: assert (trapEn || !ovfFlag)
      else $error("overflow with trap disabled");
    p_quiet_ops_r7: assert (isAdd || isSub || !ovfFlag)
      else $error("overflow on non-arithmetic op");
    p_mixed_sign_r5: assert (!(isAdd && (opA[MSB] != bUsed[MSB])) || !ovfFlag)
      else $error("overflow on mixed-sign add");
    p_same_sign_sub_r5: assert (!(isSub && (opA[MSB] == bUsed[MSB])) || !ovfFlag)
      else $error("overflow on same-sign subtract");
    p_cmp_bool_r8: assert (!isCmp || (result[DATA_W-1:1] == '0))
      else $error("compare result not 0/1");
    p_undefined_r12: assert (opSel < 8 || (result == '0 && !ovfFlag))
      else $error("undefined op produced output");
  end

endmodule

bind alu_core alu_core_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OP_W(OP_W)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .immVal   (immVal),
  .useImm   (useImm),
  .opSel    (opSel),
  .trapEn   (trapEn),
  .result   (result),
  .zeroFlag (zeroFlag),
  .ovfFlag  (ovfFlag)
);

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] immVal = '0;
  logic        useImm = 1'b0;
  logic [3:0]  opSel = '0;
  logic        trapEn = 1'b0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu_core uut (
    .opA(opA), .opB(opB), .immVal(immVal), .useImm(useImm),
    .opSel(opSel), .trapEn(trapEn),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  // independent reference built from the requirement text
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic ui, input logic te,
                       output logic [31:0] r, output logic v);
    logic [31:0] bx;
    longint sa, sb, wide;
    if (ui) bx = (op >= 4 && op <= 7) ? 32'($signed(im)) : {16'h0, im};
    else    bx = b;
    sa = longint'($signed(a));
    sb = longint'($signed(bx));
    r = 32'h0;
    v = 1'b0;
    case (op)
      4'd0: r = a & bx;
      4'd1: r = a | bx;
      4'd2: r = a ^ bx;
      4'd3: r = ~(a | bx);
      4'd4: begin
        r = a + bx; wide = sa + sb;
        v = te && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4'd5: begin
        r = a - bx; wide = sa - sb;
        v = te && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4'd6: r = (sa < sb) ? 32'd1 : 32'd0;
      4'd7: r = (a < bx) ? 32'd1 : 32'd0;
      default: r = 32'h0;
    endcase
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic ui, input logic te,
                       input string tag);
    logic [31:0] er;
    logic        ev;
    @(negedge clk);
    opSel = op; opA = a; opB = b; immVal = im; useImm = ui; trapEn = te;
    model(op, a, b, im, ui, te, er, ev);
    @(posedge clk);
    #1;
    checks++;
    if (result !== er || ovfFlag !== ev || zeroFlag !== (er == 32'h0)) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: result=%h ovf=%b zero=%b expected result=%h ovf=%b zero=%b",
               tag, op, a, b, result, ovfFlag, zeroFlag, er, ev, (er == 32'h0));
    end
  endtask

  task automatic test_reset;
    apply(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, "R11 idle");
  endtask

  task automatic test_logic;   // R1
    apply(4'd0, 32'hF0F0_1234, 32'hFF00_FF0F, 16'h0, 1'b0, 1'b1, "R1 and");
    apply(4'd1, 32'hF0F0_1234, 32'h0F00_0001, 16'h0, 1'b0, 1'b1, "R1 or");
    apply(4'd2, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 1'b0, 1'b1, "R1 xor");
    apply(4'd3, 32'h1200_0034, 32'h0000_5600, 16'h0, 1'b0, 1'b1, "R1 nor");
  endtask

  task automatic test_addsub;  // R2
    apply(4'd4, 32'd7, 32'd6, 16'h0, 1'b0, 1'b1, "R2 add");
    apply(4'd4, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b1, "R2 add wrap");
    apply(4'd5, 32'd7, 32'd6, 16'h0, 1'b0, 1'b1, "R2 sub");
    apply(4'd5, 32'd3, 32'd9, 16'h0, 1'b0, 1'b1, "R2 sub negative");
  endtask

  task automatic test_ovf_add; // R3
    apply(4'd4, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b1, "R3 pos+pos");
    apply(4'd4, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b1, "R3 neg+neg");
    apply(4'd4, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b1, "R3 min+min");
    apply(4'd4, 32'h4000_0000, 32'h3FFF_FFFF, 16'h0, 1'b0, 1'b1, "R3 max no ovf");
  endtask

  task automatic test_ovf_sub; // R4
    apply(4'd5, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b1, "R4 pos-neg");
    apply(4'd5, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b1, "R4 neg-pos");
    apply(4'd5, 32'h0000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b1, "R4 zero-min");
  endtask

  task automatic test_no_ovf;  // R5
    apply(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 1'b1, "R5 mixed add");
    apply(4'd5, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b1, "R5 neg-neg");
    apply(4'd5, 32'h7FFF_FFFF, 32'h0000_0000, 16'h0, 1'b0, 1'b1, "R5 pos-pos");
  endtask

  task automatic test_trap_off; // R6
    apply(4'd4, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0, "R6 add quiet");
    apply(4'd5, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b0, "R6 sub quiet");
  endtask

  task automatic test_quiet_ops; // R7
    apply(4'd6, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 1'b1, "R7 slt no ovf");
    apply(4'd2, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b1, "R7 xor no ovf");
  endtask

  task automatic test_slt;     // R8
    apply(4'd6, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0, "R8 -1<1");
    apply(4'd6, 32'd1, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0, "R8 1<-1");
    apply(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b0, "R8 min<max overflowing");
    apply(4'd6, 32'd5, 32'd5, 16'h0, 1'b0, 1'b0, "R8 equal");
  endtask

  task automatic test_sltu;    // R9
    apply(4'd7, 32'd1, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0, "R9 1<max");
    apply(4'd7, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0, "R9 max<1");
    apply(4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 1'b0, "R9 cross half");
  endtask

  task automatic test_imm;     // R10
    apply(4'd4, 32'd10, 32'hDEAD_BEEF, 16'hFFFF, 1'b1, 1'b1, "R10 addi -1");
    apply(4'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1, 1'b1, "R10 andi zero-ext");
    apply(4'd1, 32'h0, 32'h0, 16'h8000, 1'b1, 1'b1, "R10 ori zero-ext");
    apply(4'd2, 32'h1234_0000, 32'h0, 16'hF00F, 1'b1, 1'b1, "R10 xori zero-ext");
    apply(4'd6, 32'd0, 32'h0, 16'h8000, 1'b1, 1'b1, "R10 slti neg imm");
    apply(4'd7, 32'd5, 32'h0, 16'hFFFF, 1'b1, 1'b1, "R10 sltiu sign-ext");
  endtask

  task automatic test_zero;    // R11
    apply(4'd5, 32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0, 1'b1, "R11 sub to zero");
    apply(4'd3, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 1'b0, 1'b1, "R11 nor to zero");
  endtask

  task automatic test_undef;   // R12
    for (int k = 8; k < 16; k++)
      apply(4'(k), 32'h7FFF_FFFF, 32'd1, 16'h1, 1'b0, 1'b1, "R12 undefined code");
  endtask

  initial begin
    test_reset();
    test_logic();
    test_addsub();
    test_ovf_add();
    test_ovf_sub();
    test_no_ovf();
    test_trap_off();
    test_quiet_ops();
    test_slt();
    test_sltu();
    test_imm();
    test_zero();
    test_undef();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule